// File: doc/BRIEF.md
# Multiplexed Bus Master Strobe Generator

This block drives the control side of a 16-bit multiplexed address/data bus while a network controller moves data by DMA. A requester presents one transfer at a time: a 24-bit address, a byte or word size, a flag that marks data coming from the transfer FIFO, and the write word. Once the bus is granted, the block runs a fixed phase sequence. In the address phase it places the low address on the shared lines and the high address on a separate bus. In the data phase it places the data. A final end phase gives the shared lines back before the block returns to rest.

Three configuration inputs shape the pins. The first makes the address strobe either a level latch-enable or a low-going pulse. The second makes the two select pins either a two-bit byte mask or a size flag paired with an acknowledge output for a grant daisy chain. The third swaps the two data bytes, but only for FIFO traffic. The configuration is read while the block is at rest and is held for the whole bus cycle. A word request at an odd address is refused when the size-flag pin style is selected.

Top module: `dma_bus_strobe`

## Requirements
- R1: After reset, every master output enable (`dal_oe`, `addr_hi_oe`, `strobe_oe`, `sel0_oe`) is low, `xfer_done` and `xfer_err` are low, and `busak_n` is high while `hold_ack` is low.
- R2: A granted cycle spends one clock in the address phase, DATA_CYCLES clocks (default 2) in the data phase and one clock in the end phase, then returns to rest. `xfer_done` is high only during the end phase.
- R3: With `cfg_as_mode`=0 the strobe is a latch enable: it is high in the address phase and low in the data and end phases.
- R4: With `cfg_as_mode`=1 the strobe is a pulse: it is low in the address phase and high in the data and end phases.
- R5: In the address phase `dal_out` equals address bits 15:0. `addr_hi` equals bits 23:16 throughout the cycle. `dal_oe` is high only in the address and data phases. `addr_hi_oe` and `strobe_oe` are high only while the block is master.
- R6: With `cfg_byte_pin`=0 the pair {`sel1`,`sel0`} is a byte mask: 00 for a word, 01 for a byte at an odd address (upper byte), 10 for a byte at an even address (lower byte). Both pins are enabled only while the block is master.
- R7: With `cfg_byte_pin`=1, `sel0` is the size flag (1 = byte, 0 = word) and is enabled only while the block is master. `sel1` carries `busak_n` and is always enabled.
- R8: `busak_n` is low exactly when `hold_ack` is high and `hold_req` is low.
- R9: In the data phase `dal_out` carries `req_wdata` with its two bytes exchanged when both `cfg_swap` and `req_fifo` are 1, and carries it unchanged otherwise.
- R10: A word request at an odd address while `cfg_byte_pin`=1 raises `xfer_err` in every idle cycle in which it is presented, keeps `hold_req` low, and starts no cycle.
- R11: A change of the configuration inputs during a bus cycle has no effect on the pins until the block is back at rest.
- R12: A legal request without `hold_ack` keeps the block at rest with `hold_req` high. The cycle starts on the first clock at which `hold_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request pending |
| req_addr | input | 24 | Transfer address |
| req_byte | input | 1 | 1 = byte transfer, 0 = word |
| req_fifo | input | 1 | Data belongs to the transfer FIFO |
| req_wdata | input | 16 | Write data |
| cfg_as_mode | input | 1 | Strobe style: 0 level latch enable, 1 low pulse |
| cfg_byte_pin | input | 1 | Select pin style: 0 byte mask, 1 size flag plus acknowledge |
| cfg_swap | input | 1 | Exchange data bytes for FIFO traffic |
| hold_ack | input | 1 | Bus grant |
| hold_req | output | 1 | Block wants or holds the bus |
| busak_n | output | 1 | Daisy-chain acknowledge, active low |
| dal_out | output | 16 | Multiplexed address/data lines |
| dal_oe | output | 1 | Drive enable for `dal_out` |
| addr_hi | output | 8 | Address bits 23:16 |
| addr_hi_oe | output | 1 | Drive enable for `addr_hi` |
| strobe | output | 1 | Address strobe (latch enable or pulse) |
| strobe_oe | output | 1 | Drive enable for `strobe` |
| sel0 | output | 1 | Byte mask bit 0 or size flag |
| sel0_oe | output | 1 | Drive enable for `sel0` |
| sel1 | output | 1 | Byte mask bit 1 or daisy-chain acknowledge |
| sel1_oe | output | 1 | Drive enable for `sel1` |
| xfer_done | output | 1 | End phase of a cycle |
| xfer_err | output | 1 | Misaligned word request refused |

## Verification
The grant input can arrive in the same clock as the refusal of a misaligned word request. In that clock the refused request must not count as a request, so the acknowledge output has to fall while the error flag is high. The bench provokes this by presenting an odd-address word request with the size-flag pin style selected and the grant already high. It also provokes the opposite case, a legal request that meets the grant, where the acknowledge must stay high and a cycle must start. A behavioural model judges both cases cycle by cycle from the live inputs and its own phase counter.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DAL_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_END  = 2'd3
  } dbs_state_e;

  typedef struct packed {
    logic as_mode;
    logic byte_pin;
    logic swap;
  } dbs_cfg_t;

  // {mask1, mask0}: 00 word, 01 upper (odd) byte, 10 lower (even) byte
  function automatic logic [1:0] lane_mask(input logic is_byte, input logic a0);
    if (!is_byte) return 2'b00;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  function automatic logic misaligned_word(input logic byte_pin, input logic is_byte,
                                           input logic a0);
    return byte_pin & ~is_byte & a0;
  endfunction

  function automatic logic [DAL_W-1:0] swap_bytes(input logic [DAL_W-1:0] w);
    return {w[DAL_W/2-1:0], w[DAL_W-1:DAL_W/2]};
  endfunction
endpackage

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int DATA_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output dbs_state_e state,
  output logic       ph_addr,
  output logic       ph_data,
  output logic       ph_end
);
  logic data_last;

  generate
    if (DATA_CYCLES > 1) begin : g_wait
      localparam int CW = $clog2(DATA_CYCLES);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (state != ST_DATA) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
      end
      assign data_last = (cnt == CW'(DATA_CYCLES - 1));
    end else begin : g_nowait
      assign data_last = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (start) state <= ST_ADDR;
        ST_ADDR: state <= ST_DATA;
        ST_DATA: if (data_last) state <= ST_END;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ph_addr = (state == ST_ADDR);
  assign ph_data = (state == ST_DATA);
  assign ph_end  = (state == ST_END);
endmodule

// File: rtl/dbs_chain.sv
module dbs_chain (
  input  logic hold_ack,
  input  logic busy,
  input  logic want,
  output logic hold_req,
  output logic busak_n
);
  assign hold_req = busy | want;
  assign busak_n  = ~(hold_ack & ~hold_req);
endmodule

// File: rtl/dbs_pins.sv
module dbs_pins
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int HI_W  = ADDR_W - DAL_W
) (
  input  logic              ph_addr,
  input  logic              ph_data,
  input  logic              ph_end,
  input  dbs_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_byte,
  input  logic              is_fifo,
  input  logic [DAL_W-1:0]  wdata,
  input  logic              busak_n,
  output logic [DAL_W-1:0]  dal_out,
  output logic              dal_oe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic              strobe,
  output logic              strobe_oe,
  output logic              sel0,
  output logic              sel0_oe,
  output logic              sel1,
  output logic              sel1_oe
);
  logic       master;
  logic [1:0] mask;

  assign master = ph_addr | ph_data | ph_end;
  assign mask   = lane_mask(is_byte, addr[0]);

  always_comb begin
    dal_out = '0;
    if (ph_addr)      dal_out = addr[DAL_W-1:0];
    else if (ph_data) dal_out = (cfg.swap & is_fifo) ? swap_bytes(wdata) : wdata;
  end

  assign dal_oe     = ph_addr | ph_data;
  assign addr_hi    = master ? addr[ADDR_W-1:DAL_W] : '0;
  assign addr_hi_oe = master;
  assign strobe     = master & (cfg.as_mode ? ~ph_addr : ph_addr);
  assign strobe_oe  = master;
  assign sel0       = master & (cfg.byte_pin ? is_byte : mask[0]);
  assign sel0_oe    = master;
  assign sel1       = cfg.byte_pin ? busak_n : (master & mask[1]);
  assign sel1_oe    = cfg.byte_pin | master;
endmodule

// File: rtl/dma_bus_strobe.sv
module dma_bus_strobe
  import dbs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_CYCLES = 2,
  localparam int HI_W       = ADDR_W - DAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  input  logic              req_fifo,
  input  logic [DAL_W-1:0]  req_wdata,
  input  logic              cfg_as_mode,
  input  logic              cfg_byte_pin,
  input  logic              cfg_swap,
  input  logic              hold_ack,
  output logic              hold_req,
  output logic              busak_n,
  output logic [DAL_W-1:0]  dal_out,
  output logic              dal_oe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic              strobe,
  output logic              strobe_oe,
  output logic              sel0,
  output logic              sel0_oe,
  output logic              sel1,
  output logic              sel1_oe,
  output logic              xfer_done,
  output logic              xfer_err
);
  dbs_state_e        state;
  logic              ph_addr, ph_data, ph_end, idle;
  logic              refused, start;
  dbs_cfg_t          cfg_live, cfg_q, cfg_eff;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_q, fifo_q;
  logic [DAL_W-1:0]  wdata_q;

  assign cfg_live = '{as_mode: cfg_as_mode, byte_pin: cfg_byte_pin, swap: cfg_swap};
  assign idle     = (state == ST_IDLE);
  assign cfg_eff  = idle ? cfg_live : cfg_q;
  assign refused  = idle & req_valid & misaligned_word(cfg_live.byte_pin, req_byte, req_addr[0]);
  assign start    = idle & req_valid & ~refused & hold_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      byte_q  <= 1'b0;
      fifo_q  <= 1'b0;
      wdata_q <= '0;
    end else if (idle) begin
      cfg_q <= cfg_live;
      if (start) begin
        addr_q  <= req_addr;
        byte_q  <= req_byte;
        fifo_q  <= req_fifo;
        wdata_q <= req_wdata;
      end
    end
  end

  dbs_seq #(.DATA_CYCLES(DATA_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state),
    .ph_addr(ph_addr), .ph_data(ph_data), .ph_end(ph_end)
  );

  dbs_chain u_chain (
    .hold_ack(hold_ack), .busy(~idle), .want(req_valid & ~refused),
    .hold_req(hold_req), .busak_n(busak_n)
  );

  dbs_pins #(.ADDR_W(ADDR_W)) u_pins (
    .ph_addr(ph_addr), .ph_data(ph_data), .ph_end(ph_end), .cfg(cfg_eff),
    .addr(addr_q), .is_byte(byte_q), .is_fifo(fifo_q), .wdata(wdata_q),
    .busak_n(busak_n),
    .dal_out(dal_out), .dal_oe(dal_oe), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .strobe(strobe), .strobe_oe(strobe_oe), .sel0(sel0), .sel0_oe(sel0_oe),
    .sel1(sel1), .sel1_oe(sel1_oe)
  );

  assign xfer_done = ph_end;
  assign xfer_err  = refused;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker (
  input logic clk,
  input logic rst_n,
  input logic ph_addr,
  input logic ph_data,
  input logic ph_end,
  input logic as_q,
  input logic hold_ack,
  input logic hold_req,
  input logic busak_n,
  input logic dal_oe,
  input logic addr_hi_oe,
  input logic strobe,
  input logic strobe_oe,
  input logic sel0,
  input logic sel0_oe,
  input logic xfer_err
);
  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_addr, ph_data, ph_end}));

  assert_end_to_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_end |=> !(ph_addr || ph_data || ph_end));

  assert_ale_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_data && $past(ph_addr) && !as_q) |-> $fell(strobe));

  assert_as_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_data && $past(ph_addr) && as_q) |-> $rose(strobe));

  assert_float_at_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_addr || ph_data || ph_end) |-> !(strobe_oe || dal_oe || addr_hi_oe || sel0_oe));

  assert_chain_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack || hold_req) |-> busak_n);

  assert_refuse_nostart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !ph_addr);

  assert_sel_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0_oe && $past(sel0_oe)) |-> $stable(sel0));
endmodule

bind dma_bus_strobe dbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ph_addr(ph_addr), .ph_data(ph_data), .ph_end(ph_end),
  .as_q(cfg_q.as_mode), .hold_ack(hold_ack), .hold_req(hold_req), .busak_n(busak_n),
  .dal_oe(dal_oe), .addr_hi_oe(addr_hi_oe), .strobe(strobe), .strobe_oe(strobe_oe),
  .sel0(sel0), .sel0_oe(sel0_oe), .xfer_err(xfer_err)
);

// File: tb/dma_bus_strobe_test.sv
module dma_bus_strobe_test;
  localparam int CLK_PERIOD = 10;
  localparam int DC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_byte = 1'b0, req_fifo = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        cfg_as_mode = 1'b0, cfg_byte_pin = 1'b0, cfg_swap = 1'b0;
  logic        hold_ack = 1'b0;
  logic        hold_req, busak_n, dal_oe, addr_hi_oe, strobe, strobe_oe;
  logic        sel0, sel0_oe, sel1, sel1_oe, xfer_done, xfer_err;
  logic [15:0] dal_out;
  logic [7:0]  addr_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_strobe #(.ADDR_W(24), .DATA_CYCLES(DC)) uut (.*);

  // behavioural reference: phase 0 rest, 1 address, 2 data, 3 end
  int          m_ph = 0;
  int          m_left = 0;
  logic [23:0] m_addr;
  logic        m_byte, m_fifo, m_as, m_bp, m_sw;
  logic [15:0] m_wd;

  function automatic bit bad_now();
    return req_valid && cfg_byte_pin && !req_byte && req_addr[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (req_valid && hold_ack && !bad_now()) begin
             m_ph = 1; m_addr = req_addr; m_byte = req_byte; m_fifo = req_fifo;
             m_wd = req_wdata; m_as = cfg_as_mode; m_bp = cfg_byte_pin; m_sw = cfg_swap;
           end
        1: begin m_ph = 2; m_left = DC; end
        2: begin m_left--; if (m_left == 0) m_ph = 3; end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit rest, e_err, e_hreq, e_bk, bp, as;
    rest   = (m_ph == 0);
    e_err  = rest && bad_now();
    e_hreq = !rest || (req_valid && !e_err);
    e_bk   = !(hold_ack && !e_hreq);
    bp     = rest ? cfg_byte_pin : m_bp;
    as     = rest ? cfg_as_mode : m_as;
    chk("R10", "xfer_err", xfer_err, e_err);
    chk("R2", "xfer_done", xfer_done, m_ph == 3);
    chk("R12", "hold_req", hold_req, e_hreq);
    chk("R8", "busak_n", busak_n, e_bk);
    chk("R5", "dal_oe", dal_oe, m_ph == 1 || m_ph == 2);
    chk("R5", "addr_hi_oe", addr_hi_oe, !rest);
    chk("R5", "strobe_oe", strobe_oe, !rest);
    chk(bp ? "R7" : "R6", "sel0_oe", sel0_oe, !rest);
    chk(bp ? "R7" : "R6", "sel1_oe", sel1_oe, bp || !rest);
    if (m_ph == 1) chk("R5", "dal addr", dal_out, m_addr[15:0]);
    if (m_ph == 2)
      chk("R9", "dal data", dal_out, (m_fifo && m_sw) ? {m_wd[7:0], m_wd[15:8]} : m_wd);
    if (!rest) begin
      chk("R5", "addr_hi", addr_hi, m_addr[23:16]);
      chk(as ? "R4" : "R3", "strobe", strobe, as ? (m_ph != 1) : (m_ph == 1));
      chk(bp ? "R7" : "R6", "sel0", sel0, bp ? m_byte : (m_byte && m_addr[0]));
      if (!bp) chk("R6", "sel1", sel1, m_byte && !m_addr[0]);
    end
    if (bp) chk("R7", "sel1 ack", sel1, e_bk);
  endtask

  always @(negedge clk) if (rst_n && !finished) compare_all();

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic xfer(input logic [23:0] a, input logic byt, input logic fifo,
                      input logic [15:0] wd, input logic as, input logic bp,
                      input logic sw, input int grant_delay);
    req_addr = a; req_byte = byt; req_fifo = fifo; req_wdata = wd;
    cfg_as_mode = as; cfg_byte_pin = bp; cfg_swap = sw;
    req_valid = 1'b1; hold_ack = (grant_delay == 0);
    for (int i = 0; i < grant_delay; i++) step();
    hold_ack = 1'b1;
    for (int i = 0; i < 40 && m_ph != 3; i++) step();
    req_valid = 1'b0;
    step();
    hold_ack = 1'b0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "dal_oe", dal_oe, 0);
    chk("R1", "strobe_oe", strobe_oe, 0);
    chk("R1", "addr_hi_oe", addr_hi_oe, 0);
    chk("R1", "sel0_oe", sel0_oe, 0);
    chk("R1", "busak_n", busak_n, 1);
    chk("R1", "xfer_done", xfer_done, 0);
    rst_n = 1'b1;
    step();

    // byte mask, latch enable, even word
    xfer(24'h12_3456, 0, 0, 16'hA1B2, 0, 0, 0, 0);
    // byte mask, pulse strobe, even and odd bytes
    xfer(24'hAB_0010, 1, 0, 16'h00C3, 1, 0, 0, 0);
    xfer(24'hAB_0011, 1, 0, 16'hD400, 1, 0, 0, 0);
    // word at odd address is legal with byte mask style
    xfer(24'h01_0203, 0, 1, 16'h5566, 0, 0, 1, 0);
    // grant arrives late (R12)
    xfer(24'h77_8000, 0, 0, 16'h1234, 0, 1, 0, 3);
    // size flag style, fifo data with and without swap (R9)
    xfer(24'h00_4444, 0, 1, 16'hBEEF, 1, 1, 1, 0);
    xfer(24'h00_4445, 1, 1, 16'hCA00, 0, 1, 1, 0);
    xfer(24'h00_4446, 0, 0, 16'hF00D, 1, 1, 1, 0);

    // grant with no request: acknowledge passes down (R8)
    cfg_byte_pin = 1'b1; hold_ack = 1'b1;
    step();
    @(negedge clk);
    chk("R8", "busak_n idle grant", busak_n, 0);
    chk("R7", "sel1 idle grant", sel1, 0);
    step();

    // refused request meeting the grant in the same cycle (R10, R8)
    req_addr = 24'h00_0101; req_byte = 1'b0; req_valid = 1'b1;
    step();
    @(negedge clk);
    chk("R10", "xfer_err", xfer_err, 1);
    chk("R10", "hold_req", hold_req, 0);
    chk("R8", "busak_n on refusal", busak_n, 0);
    step();
    @(negedge clk);
    chk("R10", "no start strobe_oe", strobe_oe, 0);
    req_valid = 1'b0; hold_ack = 1'b0;
    step();

    // configuration flipped mid-cycle (R11)
    cfg_as_mode = 1'b0; cfg_byte_pin = 1'b0; cfg_swap = 1'b0;
    req_addr = 24'h3C_2A10; req_byte = 1'b1; req_fifo = 1'b1; req_wdata = 16'h0099;
    req_valid = 1'b1; hold_ack = 1'b1;
    step();
    step();
    cfg_as_mode = 1'b1; cfg_byte_pin = 1'b1; cfg_swap = 1'b1;
    @(negedge clk);
    chk("R11", "strobe kept latch style", strobe, 0);
    chk("R11", "sel1 kept mask", sel1, 1);
    chk("R11", "data not swapped", dal_out, 16'h0099);
    for (int i = 0; i < 40 && m_ph != 3; i++) step();
    req_valid = 1'b0;
    step();
    hold_ack = 1'b0;
    step();
    @(negedge clk);
    chk("R11", "new style at rest sel1_oe", sel1_oe, 1);
    step();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule